// File: doc/BRIEF.md
# GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins, `NPINS`, which must be a multiple of 32. Each pin has the following controls:

- a direction bit;
- an output latch, changed by write-one set and write-one clear registers;
- a synchronized level that can be read back;
- separate enables for rising edges and for falling edges;
- a sticky edge-status bit that is cleared by writing 1 to it;
- a two-bit function selector.

For each pin the block drives an output-enable and an output-value signal toward a tri-state pad. It also drives one combined interrupt line, which stays high while any edge-status bit is pending.

Registers are grouped by feature. Each feature takes `NW = NPINS/32` consecutive 32-bit words, so software finds a pin's bit as word `pin/32`, bit `pin%32` of the feature's group. The function selector is the last group and is twice as wide: 16 pins per word.

The register bus is a plain control port and has no back-pressure. A request is presented for one cycle with `bus_en` high and is always accepted in that cycle. Read data comes back in the next cycle with `bus_rvalid`.

Top module: `gpio_ctrl`

## Requirements
- R1: A register's byte address is `feature*NW*4 + word*4`. The feature codes are:
  - 0: level
  - 1: direction
  - 2: set
  - 3: clear
  - 4: rise enable
  - 5: fall enable
  - 6: edge status
  - 7: function, which spans 2*NW words.

  After reset every register, `pin_oe`, `pin_out`, `pin_func` and `irq` read 0.
- R2: Direction bit 1 makes the pin an output (`pin_oe` high); 0 makes it an input. A read returns the value written.
- R3: Writing 1 to a set-register bit drives that pin's `pin_out` high from the cycle after the write. Bits written as 0 have no effect, and a read of the set register returns 0.
- R4: Writing 1 to a clear-register bit drives that pin's `pin_out` low. Bits written as 0 have no effect, and a read of the clear register returns 0.
- R5: A read of the level register returns `pin_in` after a two-flop synchronizer, so a level is readable from the second rising edge after it appears. Writes to the level register are ignored.
- R6: The rise enable records 0-to-1 changes and the fall enable records 1-to-0 changes, independently. With both enables set, either direction is recorded; with neither set, nothing is. A status bit sets at the third rising clock edge after the input change.
- R7: Edge-status bits stay set until a 1 is written to them. Bits written as 0 are unaffected, and writing all ones clears every pending bit.
- R8: If a new edge arrives in the same cycle as a write-1 clear of the same status bit, the bit stays set.
- R9: `irq` is high exactly while at least one edge-status bit is set.
- R10: The function field holds 2 bits per pin, in word `pin/16` of the function group at bit `(pin%16)*2`. `pin_func[2*pin+1:2*pin]` shows the same value, and a read returns it.
- R11: `bus_rvalid` is high in the cycle after an accepted read and low after a write. Addresses beyond the map read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Request strobe, accepted in the same cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| pin_oe | output | NPINS | Per-pin output enable |
| pin_out | output | NPINS | Per-pin output value |
| pin_func | output | 2*NPINS | Per-pin function selector, 0 = plain GPIO |
| irq | output | 1 | Combined edge interrupt |

## Verification
The faults that matter here are visible at the ports, each within a few cycles:

- A wrong output latch or direction word appears on `pin_oe`/`pin_out` one cycle after the write that caused it.
- A mis-decoded address shows up as a readback landing in the wrong feature or word.
- A broken edge path shows on `irq` exactly three clock edges after a pin change. An extra synchronizer stage, a missing one, or an ignored enable therefore moves or suppresses that rise by a known cycle.
- Lost status bits show up in a status read made right after a clear collides with a fresh edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int REG_W      = 32;
  localparam int WORD_BYTES = REG_W / 8;

  typedef enum logic [2:0] {
    FEAT_LEVEL = 3'd0,
    FEAT_DIR   = 3'd1,
    FEAT_SET   = 3'd2,
    FEAT_CLR   = 3'd3,
    FEAT_RISE  = 3'd4,
    FEAT_FALL  = 3'd5,
    FEAT_STAT  = 3'd6,
    FEAT_FUNC  = 3'd7
  } gpio_feat_e;

  // Word index (address / 4) of a feature group word
  function automatic int reg_word(input int feat, input int word, input int nw);
    return feat * nw + word;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] rise_evt,
  output logic [NPINS-1:0] fall_evt
);

  logic [STAGES-1:0][NPINS-1:0] stage_q;
  logic [NPINS-1:0]             prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q[0] <= pin_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], pin_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign level    = stage_q[STAGES-1];
  assign rise_evt =  level & ~prev_q;
  assign fall_evt = ~level &  prev_q;

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] rise_evt,
  input  logic [NPINS-1:0] fall_evt,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] status,
  output logic             irq
);

  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] status_q;

  assign evt = (rise_evt & rise_en) | (fall_evt & fall_en);

  // A fresh edge overrides a simultaneous clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | evt;
  end

  assign status = status_q;
  assign irq    = |status_q;

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt))); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|clr_mask) && !(|evt)) |=> $stable(status_q)); // R7
  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((status_q & $past(clr_mask & ~evt)) == '0)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|evt)); // R9

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int NW     = NPINS / 32,
  parameter int ADDR_W = $clog2(9 * NW * 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               bus_rvalid,
  input  logic [NPINS-1:0]   level,
  input  logic [NPINS-1:0]   status,
  output logic [NPINS-1:0]   dir,
  output logic [NPINS-1:0]   out_val,
  output logic [NPINS-1:0]   rise_en,
  output logic [NPINS-1:0]   fall_en,
  output logic [2*NPINS-1:0] func,
  output logic [NPINS-1:0]   stat_clr
);

  localparam int FNW = 2 * NW;

  logic [31:0]        widx;
  logic               wr, rd;
  logic [NPINS-1:0]   dir_m, rise_m, fall_m, set_m, clr_m;
  logic [2*NPINS-1:0] func_m;
  logic [NPINS-1:0]   dir_q, out_q, rise_q, fall_q;
  logic [2*NPINS-1:0] func_q;
  logic [REG_W-1:0]   rd_word, rdata_q;
  logic               rvalid_q;

  assign widx = 32'(bus_addr[ADDR_W-1:2]);
  assign wr   = bus_en &  bus_we;
  assign rd   = bus_en & ~bus_we;

  always_comb begin
    dir_m   = '0;
    rise_m  = '0;
    fall_m  = '0;
    set_m   = '0;
    clr_m   = '0;
    func_m  = '0;
    rd_word = '0;
    for (int w = 0; w < NW; w++) begin
      if (widx == 32'(reg_word(int'(FEAT_LEVEL), w, NW))) rd_word = level[w*REG_W +: REG_W];
      if (widx == 32'(reg_word(int'(FEAT_DIR), w, NW))) begin
        rd_word = dir_q[w*REG_W +: REG_W];
        if (wr) dir_m[w*REG_W +: REG_W] = '1;
      end
      if (widx == 32'(reg_word(int'(FEAT_SET), w, NW)) && wr)
        set_m[w*REG_W +: REG_W] = bus_wdata;
      if (widx == 32'(reg_word(int'(FEAT_CLR), w, NW)) && wr)
        clr_m[w*REG_W +: REG_W] = bus_wdata;
      if (widx == 32'(reg_word(int'(FEAT_RISE), w, NW))) begin
        rd_word = rise_q[w*REG_W +: REG_W];
        if (wr) rise_m[w*REG_W +: REG_W] = '1;
      end
      if (widx == 32'(reg_word(int'(FEAT_FALL), w, NW))) begin
        rd_word = fall_q[w*REG_W +: REG_W];
        if (wr) fall_m[w*REG_W +: REG_W] = '1;
      end
      if (widx == 32'(reg_word(int'(FEAT_STAT), w, NW))) rd_word = status[w*REG_W +: REG_W];
    end
    for (int j = 0; j < FNW; j++) begin
      if (widx == 32'(reg_word(int'(FEAT_FUNC), j, NW))) begin
        rd_word = func_q[j*REG_W +: REG_W];
        if (wr) func_m[j*REG_W +: REG_W] = '1;
      end
    end
  end

  // Status clear mask: write data on the addressed status word only
  always_comb begin
    stat_clr = '0;
    for (int w = 0; w < NW; w++)
      if (wr && widx == 32'(reg_word(int'(FEAT_STAT), w, NW)))
        stat_clr[w*REG_W +: REG_W] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      func_q <= '0;
    end else begin
      dir_q  <= (dir_q  & ~dir_m)  | ({NW{bus_wdata}}  & dir_m);
      rise_q <= (rise_q & ~rise_m) | ({NW{bus_wdata}}  & rise_m);
      fall_q <= (fall_q & ~fall_m) | ({NW{bus_wdata}}  & fall_m);
      func_q <= (func_q & ~func_m) | ({FNW{bus_wdata}} & func_m);
      out_q  <= (out_q | set_m) & ~clr_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_word;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign dir        = dir_q;
  assign out_val    = out_q;
  assign rise_en    = rise_q;
  assign fall_en    = fall_q;
  assign func       = func_q;

  AST_SET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_m) |=> ((out_q & $past(set_m)) == $past(set_m))); // R3
  AST_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_m) |=> ((out_q & $past(clr_m)) == '0)); // R4
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_m) && !(|clr_m)) |=> $stable(out_q)); // R3

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS  = 64,
  parameter int NW     = NPINS / 32,
  parameter int ADDR_W = $clog2(9 * NW * 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pin_out,
  output logic [2*NPINS-1:0] pin_func,
  output logic               irq
);

  logic [NPINS-1:0] level, rise_evt, fall_evt;
  logic [NPINS-1:0] rise_en, fall_en, stat_clr, status;

  gpio_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .level    (level),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  gpio_regfile #(.NPINS(NPINS), .NW(NW), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .level      (level),
    .status     (status),
    .dir        (pin_oe),
    .out_val    (pin_out),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .func       (pin_func),
    .stat_clr   (stat_clr)
  );

  gpio_edge_status #(.NPINS(NPINS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .clr_mask (stat_clr),
    .status   (status),
    .irq      (irq)
  );

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid); // R11
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_en && !bus_we)) |=> !bus_rvalid); // R11
  AST_OE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && bus_we) |=> $stable(pin_oe)); // R2

endmodule

// File: tb/gpio_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_tb;
  localparam int NPINS = 64;
  localparam int NW    = NPINS / 32;
  localparam int AW    = $clog2(9 * NW * 4);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, irq;
  logic [NPINS-1:0] pin_in = '0, pin_oe, pin_out;
  logic [2*NPINS-1:0] pin_func;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [NPINS-1:0] m_dir = '0, m_out = '0, m_rise = '0, m_fall = '0;
  logic [2*NPINS-1:0] m_func = '0;

  gpio_ctrl #(.NPINS(NPINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_func(pin_func), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] ra(input int feat, input int word);
    return AW'(feat * NW * 4 + word * 4);
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Tasks start and end on a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r, d;
    logic [NPINS-1:0] pv;
    void'($urandom(32'd9137));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 reset pins", {pin_oe, pin_out, irq}, '0);
    chk("R1 reset func", pin_func, '0);
    for (int f = 1; f < 7; f++)
      for (int w = 0; w < NW; w++) begin
        rd(ra(f, w), r);
        chk("R1 reset reg", r, 0);
      end
    for (int j = 0; j < 2 * NW; j++) begin
      rd(ra(7, j), r);
      chk("R1 reset func reg", r, 0);
    end

    // R11: read valid timing
    bus_en = 1; bus_we = 0; bus_addr = ra(1, 0);
    @(negedge clk); bus_en = 0;
    chk("R11 rvalid after read", bus_rvalid, 1);
    wr(ra(1, 0), 32'h0);
    chk("R11 no rvalid after write", bus_rvalid, 0);
    rd(AW'(9 * NW * 4), r);
    chk("R11 unmapped reads 0", r, 0);

    // Random register traffic against a model (R2 R3 R4 R10)
    for (int i = 0; i < 400; i++) begin
      int op, w, j;
      op = $urandom_range(0, 5);
      w = $urandom_range(0, NW - 1);
      j = $urandom_range(0, 2 * NW - 1);
      d = $urandom;
      case (op)
        0: begin wr(ra(1, w), d); m_dir[w*32 +: 32] = d; end
        1: begin wr(ra(2, w), d); m_out[w*32 +: 32] = m_out[w*32 +: 32] | d; end
        2: begin wr(ra(3, w), d); m_out[w*32 +: 32] = m_out[w*32 +: 32] & ~d; end
        3: begin wr(ra(4, w), d); m_rise[w*32 +: 32] = d; end
        4: begin wr(ra(5, w), d); m_fall[w*32 +: 32] = d; end
        default: begin wr(ra(7, j), d); m_func[j*32 +: 32] = d; end
      endcase
      chk("R2 pin_oe", pin_oe, m_dir);
      chk("R3 R4 pin_out", pin_out, m_out);
      chk("R10 pin_func", pin_func, m_func);
    end
    for (int w = 0; w < NW; w++) begin
      rd(ra(1, w), r); chk("R2 dir readback", r, m_dir[w*32 +: 32]);
      rd(ra(2, w), r); chk("R3 set reads 0", r, 0);
      rd(ra(3, w), r); chk("R4 clear reads 0", r, 0);
      rd(ra(4, w), r); chk("R6 rise readback", r, m_rise[w*32 +: 32]);
      rd(ra(5, w), r); chk("R6 fall readback", r, m_fall[w*32 +: 32]);
    end
    for (int j = 0; j < 2 * NW; j++) begin
      rd(ra(7, j), r); chk("R10 func readback", r, m_func[j*32 +: 32]);
    end

    // R3 R4 directed: zero bits have no effect
    wr(ra(2, 0), 32'h0000_0001); wr(ra(2, 0), 32'h0);
    chk("R3 set bit0 and zero write", pin_out[0], 1);
    wr(ra(3, 0), 32'h0);
    chk("R4 zero clear no effect", pin_out[0], 1);
    wr(ra(3, 0), 32'h0000_0001);
    chk("R4 clear bit0", pin_out[0], 0);
    m_out[0] = 0;

    // R10 directed: pin 16 lives in function word 1, bits 1:0
    wr(ra(7, 1), 32'h0000_000C);
    chk("R10 pin17 func", pin_func[35:34], 2'b11);
    chk("R10 pin16 func", pin_func[33:32], 2'b00);
    wr(ra(7, 1), 32'h0000_0003);
    chk("R10 pin16 func set", pin_func[33:32], 2'b11);

    // Disable edges, then level read (R5)
    for (int w = 0; w < NW; w++) begin wr(ra(4, w), 0); wr(ra(5, w), 0); end
    pv = {$urandom, $urandom};
    pin_in = pv;
    settle();
    for (int w = 0; w < NW; w++) begin
      rd(ra(0, w), r); chk("R5 level read", r, pv[w*32 +: 32]);
    end
    wr(ra(0, 0), ~pv[31:0]);
    rd(ra(0, 0), r); chk("R5 level write ignored", r, pv[31:0]);
    chk("R5 pins untouched by level write", pin_out, m_out);
    chk("R6 no enables no irq", irq, 0);
    pin_in = '0;
    settle();
    for (int w = 0; w < NW; w++) wr(ra(6, w), 32'hFFFF_FFFF);

    // R6: rise bits 7:0, fall bits 15:8
    wr(ra(4, 0), 32'h0000_00FF);
    wr(ra(5, 0), 32'h0000_FF00);
    pin_in = 64'h0000_0000_0000_FFFF;
    @(negedge clk); @(negedge clk);
    chk("R6 status not yet set after two edges", irq, 0);
    @(negedge clk);
    chk("R6 R9 irq on third edge", irq, 1);
    rd(ra(6, 0), r); chk("R6 rising recorded", r, 32'h0000_00FF);
    pin_in = '0;
    settle();
    rd(ra(6, 0), r); chk("R6 falling recorded", r, 32'h0000_FFFF);
    pin_in = 64'hFFFF_FFFF_FFFF_0000;
    settle();
    pin_in = '0;
    settle();
    rd(ra(6, 0), r); chk("R6 disabled bits ignored", r, 32'h0000_FFFF);
    rd(ra(6, 1), r); chk("R6 disabled word ignored", r, 0);

    // R7: partial and full clears
    wr(ra(6, 0), 32'h0000_000F);
    rd(ra(6, 0), r); chk("R7 partial clear", r, 32'h0000_FFF0);
    chk("R9 irq still high", irq, 1);
    wr(ra(6, 0), 32'h0);
    rd(ra(6, 0), r); chk("R7 zero write keeps", r, 32'h0000_FFF0);
    wr(ra(6, 0), 32'hFFFF_FFFF);
    chk("R9 irq low after clear", irq, 0);
    rd(ra(6, 0), r); chk("R7 full clear", r, 0);

    // R8: edge colliding with clear of the same bit
    pin_in[1:0] = 2'b11;
    settle();
    pin_in[1:0] = 2'b00;
    settle();
    rd(ra(6, 0), r); chk("R8 setup", r, 32'h3);
    pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(ra(6, 0), 32'h3);
    rd(ra(6, 0), r); chk("R8 edge wins over clear", r, 32'h1);
    wr(ra(6, 0), 32'h1);
    rd(ra(6, 0), r); chk("R7 later clear", r, 0);
    chk("R9 irq idle", irq, 0);

    finish_run();
  end
endmodule